// File: doc/BRIEF.md
# Audio Port Interrupt Controller

This block gathers FIFO status from every stereo channel pair of a multichannel audio serial port and reduces it to one interrupt request. For each channel pair it watches the fill level of the transmit FIFO and the receive FIFO and compares them against programmable trigger levels. It also catches single-cycle overflow pulses from both FIFOs and keeps them as sticky overrun flags.

Software reaches the block over a simple register bus with separate read and write strobes. Each channel pair exposes a status word, a mask word, two read-to-clear overrun registers and two trigger-level registers. Two write-only strobes flush all transmit or all receive FIFOs. The interrupt line is high when any unmasked flag of any channel pair is set.

Address layout: the upper address bits select the channel pair and the low four bits select the register index.

Top module: `aud_irq_ctrl`

## Requirements
- R1: After reset every mask word reads 0x33, every trigger level reads 0, both overrun flags of every channel are clear, `irq` is low and both flush outputs are low.
- R2: Status bit 4 (transmit low) is 1 exactly when the channel's transmit fill level is less than or equal to its transmit trigger register (the register holds the threshold minus one). The bit is not sticky and follows the level one clock after the level changes.
- R3: Status bit 0 (receive ready) is 1 exactly when the channel's receive fill level is greater than its receive trigger register. The bit is not sticky and follows the level one clock after the level changes.
- R4: A one-cycle transmit overflow pulse sets status bit 5, and a receive overflow pulse sets status bit 1. Each flag stays set until it is cleared as described in R5.
- R5: A read of index 2 returns the channel's transmit overrun flag in bit 0 and clears only that flag. A read of index 3 does the same for the receive overrun flag. Reading either index changes no other flag and no other channel.
- R6: When an overflow pulse and the clearing read of the same flag fall in the same cycle, the flag stays set afterwards, and the read returns the flag's earlier value.
- R7: The mask word at index 1 stores only bits 5, 4, 1 and 0; the other bits read as 0. A set mask bit keeps the status flag at the same bit position from raising the interrupt.
- R8: `irq` is the OR over all channels of (status AND NOT mask). It is registered and changes one clock after the status flags or the mask change.
- R9: The transmit trigger register (index 4) and the receive trigger register (index 5) are per channel, LVL_W bits wide, and read back as written.
- R10: Writing a value with bit 0 set to index 8 (with any channel field) drives `tx_flush` high for exactly the one cycle after the write. Index 9 does the same for `rx_flush`. Writing a value with bit 0 clear produces no pulse.
- R11: Read data appears one clock after the read strobe. It is 0 for unmapped indices and 0 in any cycle that follows a cycle with no read.
- R12: Register indices: 0 status (read only), 1 mask, 2 transmit overrun clear, 3 receive overrun clear, 4 transmit trigger, 5 receive trigger, 8 transmit flush, 9 receive flush. The channel pair number is address bits [ADDR_W-1:4].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register address: channel pair in the upper bits, index in bits 3:0 |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid one clock after `reg_rd` |
| tx_level | input | NUM_CH*LVL_W | Transmit FIFO fill level for each channel pair |
| rx_level | input | NUM_CH*LVL_W | Receive FIFO fill level for each channel pair |
| tx_ovf | input | NUM_CH | Transmit FIFO overflow pulse for each channel pair |
| rx_ovf | input | NUM_CH | Receive FIFO overflow pulse for each channel pair |
| irq | output | 1 | Combined interrupt request |
| tx_flush | output | 1 | One-cycle flush pulse for all transmit FIFOs |
| rx_flush | output | 1 | One-cycle flush pulse for all receive FIFOs |

## Verification
A clearing read of an overrun register can land in the same cycle as a new overflow pulse on that very flag. The bench provokes this on purpose by raising the pulse during the read strobe. It then checks two things: the read returns the flag's old value, and a later status read still shows the flag set. Randomized rounds also mix mask writes, overflow pulses and level changes, and compare `irq` after each round against a model built from the bench's own record of levels, triggers, masks and sticky flags.

// File: rtl/aud_irq_pkg.sv
package aud_irq_pkg;

    localparam int REG_W = 8;

    localparam logic [3:0] IDX_STATUS  = 4'd0;
    localparam logic [3:0] IDX_MASK    = 4'd1;
    localparam logic [3:0] IDX_TXOVR   = 4'd2;
    localparam logic [3:0] IDX_RXOVR   = 4'd3;
    localparam logic [3:0] IDX_TXTRIG  = 4'd4;
    localparam logic [3:0] IDX_RXTRIG  = 4'd5;
    localparam logic [3:0] IDX_TXFLUSH = 4'd8;
    localparam logic [3:0] IDX_RXFLUSH = 4'd9;

    localparam int BIT_RXDA = 0;
    localparam int BIT_RXFO = 1;
    localparam int BIT_TXFE = 4;
    localparam int BIT_TXFO = 5;

    localparam logic [REG_W-1:0] MASK_IMPL = 8'h33;

    typedef struct packed {
        logic txfe;
        logic rxda;
        logic txfo;
        logic rxfo;
    } chan_flags_t;

    function automatic logic [REG_W-1:0] pack_flags(input chan_flags_t f);
        logic [REG_W-1:0] r;
        r           = '0;
        r[BIT_RXDA] = f.rxda;
        r[BIT_RXFO] = f.rxfo;
        r[BIT_TXFE] = f.txfe;
        r[BIT_TXFO] = f.txfo;
        return r;
    endfunction

endpackage

// File: rtl/aud_irq_chan.sv
module aud_irq_chan
    import aud_irq_pkg::*;
#(
    parameter int LVL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] tx_trig,
    input  logic [LVL_W-1:0] rx_trig,
    input  logic             tx_ovf,
    input  logic             rx_ovf,
    input  logic             clr_tx,
    input  logic             clr_rx,
    output chan_flags_t      flags
);

    chan_flags_t flags_d, flags_q;

    always_comb begin
        flags_d      = flags_q;
        flags_d.txfe = (tx_level <= tx_trig);
        flags_d.rxda = (rx_level > rx_trig);
        // a fresh overflow wins over a clearing read in the same cycle
        flags_d.txfo = tx_ovf | (flags_q.txfo & ~clr_tx);
        flags_d.rxfo = rx_ovf | (flags_q.rxfo & ~clr_rx);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags = flags_q;

    AST_TXFO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ovf |=> flags_q.txfo);                                   // R6
    AST_RXFO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ovf |=> flags_q.rxfo);                                   // R6
    AST_TXFO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q.txfo && !clr_tx) |=> flags_q.txfo);                // R4
    AST_RXFO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q.rxfo && !clr_rx) |=> flags_q.rxfo);                // R4
    AST_TXFO_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_tx && !tx_ovf) |=> !flags_q.txfo);                     // R5
    AST_RXFO_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_rx && !rx_ovf) |=> !flags_q.rxfo);                     // R5

endmodule

// File: rtl/aud_irq_regs.sv
module aud_irq_regs
    import aud_irq_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int LVL_W  = 5,
    parameter int ADDR_W = 6
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              reg_wr,
    input  logic                              reg_rd,
    input  logic [ADDR_W-1:0]                 reg_addr,
    input  logic [REG_W-1:0]                  reg_wdata,
    input  chan_flags_t [NUM_CH-1:0]          flags,
    output logic [NUM_CH-1:0][REG_W-1:0]      mask,
    output logic [NUM_CH-1:0][LVL_W-1:0]      tx_trig,
    output logic [NUM_CH-1:0][LVL_W-1:0]      rx_trig,
    output logic [NUM_CH-1:0]                 clr_tx,
    output logic [NUM_CH-1:0]                 clr_rx,
    output logic [REG_W-1:0]                  rdata,
    output logic                              tx_flush,
    output logic                              rx_flush
);

    localparam int CH_W = ADDR_W - 4;

    typedef struct packed {
        logic [NUM_CH-1:0][REG_W-1:0] mask;
        logic [NUM_CH-1:0][LVL_W-1:0] txtrig;
        logic [NUM_CH-1:0][LVL_W-1:0] rxtrig;
        logic                         txfl;
        logic                         rxfl;
        logic [REG_W-1:0]             rdata;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [CH_W-1:0] sel_ch;
    logic [3:0]      sel_idx;
    logic            ch_ok;

    assign sel_ch  = reg_addr[ADDR_W-1:4];
    assign sel_idx = reg_addr[3:0];
    assign ch_ok   = (int'(sel_ch) < NUM_CH);

    always_comb begin
        regs_d       = regs_q;
        regs_d.txfl  = 1'b0;
        regs_d.rxfl  = 1'b0;
        regs_d.rdata = '0;
        clr_tx       = '0;
        clr_rx       = '0;

        if (reg_wr) begin
            case (sel_idx)
                IDX_TXFLUSH: regs_d.txfl = reg_wdata[0];
                IDX_RXFLUSH: regs_d.rxfl = reg_wdata[0];
                IDX_MASK: begin
                    if (ch_ok) regs_d.mask[sel_ch] = reg_wdata & MASK_IMPL;
                end
                IDX_TXTRIG: begin
                    if (ch_ok) regs_d.txtrig[sel_ch] = reg_wdata[LVL_W-1:0];
                end
                IDX_RXTRIG: begin
                    if (ch_ok) regs_d.rxtrig[sel_ch] = reg_wdata[LVL_W-1:0];
                end
                default: ;
            endcase
        end

        if (reg_rd && ch_ok) begin
            case (sel_idx)
                IDX_STATUS: regs_d.rdata = pack_flags(flags[sel_ch]);
                IDX_MASK:   regs_d.rdata = regs_q.mask[sel_ch];
                IDX_TXOVR: begin
                    regs_d.rdata    = {{(REG_W-1){1'b0}}, flags[sel_ch].txfo};
                    clr_tx[sel_ch]  = 1'b1;
                end
                IDX_RXOVR: begin
                    regs_d.rdata    = {{(REG_W-1){1'b0}}, flags[sel_ch].rxfo};
                    clr_rx[sel_ch]  = 1'b1;
                end
                IDX_TXTRIG: regs_d.rdata = REG_W'(regs_q.txtrig[sel_ch]);
                IDX_RXTRIG: regs_d.rdata = REG_W'(regs_q.rxtrig[sel_ch]);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q       <= '0;
            regs_q.mask  <= {NUM_CH{MASK_IMPL}};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign mask     = regs_q.mask;
    assign tx_trig  = regs_q.txtrig;
    assign rx_trig  = regs_q.rxtrig;
    assign rdata    = regs_q.rdata;
    assign tx_flush = regs_q.txfl;
    assign rx_flush = regs_q.rxfl;

    AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> (rdata == '0));                                 // R11
    AST_TXFLUSH_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        tx_flush |-> $past(reg_wr));                                // R10
    AST_RXFLUSH_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flush |-> $past(reg_wr));                                // R10
    AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({clr_tx, clr_rx}));                                // R5

endmodule

// File: rtl/aud_irq_merge.sv
module aud_irq_merge
    import aud_irq_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  chan_flags_t [NUM_CH-1:0]     flags,
    input  logic [NUM_CH-1:0][REG_W-1:0] mask,
    output logic                         irq
);

    typedef struct packed {
        logic irq;
    } merge_t;

    merge_t merge_d, merge_q;
    logic [NUM_CH-1:0] chan_pend;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_pend
        assign chan_pend[c] = |(pack_flags(flags[c]) & ~mask[c]);
    end

    always_comb begin
        merge_d     = merge_q;
        merge_d.irq = |chan_pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) merge_q <= '0;
        else        merge_q <= merge_d;
    end

    assign irq = merge_q.irq;

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_pend == '0) |=> !irq);                                // R8
    AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_pend != '0) |=> irq);                                 // R8

endmodule

// File: rtl/aud_irq_ctrl.sv
module aud_irq_ctrl
    import aud_irq_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int LVL_W  = 5,
    parameter int ADDR_W = 4 + ((NUM_CH > 1) ? $clog2(NUM_CH) : 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_wr,
    input  logic                    reg_rd,
    input  logic [ADDR_W-1:0]       reg_addr,
    input  logic [7:0]              reg_wdata,
    output logic [7:0]              reg_rdata,
    input  logic [NUM_CH*LVL_W-1:0] tx_level,
    input  logic [NUM_CH*LVL_W-1:0] rx_level,
    input  logic [NUM_CH-1:0]       tx_ovf,
    input  logic [NUM_CH-1:0]       rx_ovf,
    output logic                    irq,
    output logic                    tx_flush,
    output logic                    rx_flush
);

    chan_flags_t [NUM_CH-1:0]          flags;
    logic [NUM_CH-1:0][REG_W-1:0]      mask;
    logic [NUM_CH-1:0][LVL_W-1:0]      tx_trig;
    logic [NUM_CH-1:0][LVL_W-1:0]      rx_trig;
    logic [NUM_CH-1:0]                 clr_tx;
    logic [NUM_CH-1:0]                 clr_rx;

    aud_irq_regs #(
        .NUM_CH (NUM_CH),
        .LVL_W  (LVL_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .flags     (flags),
        .mask      (mask),
        .tx_trig   (tx_trig),
        .rx_trig   (rx_trig),
        .clr_tx    (clr_tx),
        .clr_rx    (clr_rx),
        .rdata     (reg_rdata),
        .tx_flush  (tx_flush),
        .rx_flush  (rx_flush)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        aud_irq_chan #(
            .LVL_W (LVL_W)
        ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .tx_level (tx_level[c*LVL_W +: LVL_W]),
            .rx_level (rx_level[c*LVL_W +: LVL_W]),
            .tx_trig  (tx_trig[c]),
            .rx_trig  (rx_trig[c]),
            .tx_ovf   (tx_ovf[c]),
            .rx_ovf   (rx_ovf[c]),
            .clr_tx   (clr_tx[c]),
            .clr_rx   (clr_rx[c]),
            .flags    (flags[c])
        );
    end

    aud_irq_merge #(
        .NUM_CH (NUM_CH)
    ) u_merge (
        .clk   (clk),
        .rst_n (rst_n),
        .flags (flags),
        .mask  (mask),
        .irq   (irq)
    );

endmodule

// File: tb/aud_irq_ctrl_tb.sv
module aud_irq_ctrl_tb;

    localparam int NUM_CH = 4;
    localparam int LVL_W  = 5;
    localparam int ADDR_W = 6;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    reg_wr = 1'b0;
    logic                    reg_rd = 1'b0;
    logic [ADDR_W-1:0]       reg_addr = '0;
    logic [7:0]              reg_wdata = '0;
    logic [7:0]              reg_rdata;
    logic [NUM_CH*LVL_W-1:0] tx_level = '0;
    logic [NUM_CH*LVL_W-1:0] rx_level = '0;
    logic [NUM_CH-1:0]       tx_ovf = '0;
    logic [NUM_CH-1:0]       rx_ovf = '0;
    logic                    irq;
    logic                    tx_flush;
    logic                    rx_flush;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    int m_tx_lvl [NUM_CH];
    int m_rx_lvl [NUM_CH];
    int m_txtrig [NUM_CH];
    int m_rxtrig [NUM_CH];
    int m_mask   [NUM_CH];
    int m_txfo   [NUM_CH];
    int m_rxfo   [NUM_CH];

    always #2 clk = ~clk;

    aud_irq_ctrl #(.NUM_CH(NUM_CH), .LVL_W(LVL_W), .ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_level(tx_level), .rx_level(rx_level), .tx_ovf(tx_ovf), .rx_ovf(rx_ovf),
        .irq(irq), .tx_flush(tx_flush), .rx_flush(rx_flush)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic int adr(input int ch, input int idx);
        return ch * 16 + idx;
    endfunction

    function automatic int exp_status(input int c);
        int s = 0;
        if (m_rx_lvl[c] > m_rxtrig[c])  s |= 8'h01;
        if (m_rxfo[c] != 0)             s |= 8'h02;
        if (m_tx_lvl[c] <= m_txtrig[c]) s |= 8'h10;
        if (m_txfo[c] != 0)             s |= 8'h20;
        return s;
    endfunction

    function automatic int exp_irq();
        int r = 0;
        for (int c = 0; c < NUM_CH; c++)
            if ((exp_status(c) & ~m_mask[c] & 8'h33) != 0) r = 1;
        return r;
    endfunction

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic apply_levels();
        for (int c = 0; c < NUM_CH; c++) begin
            tx_level[c*LVL_W +: LVL_W] = LVL_W'(m_tx_lvl[c]);
            rx_level[c*LVL_W +: LVL_W] = LVL_W'(m_rx_lvl[c]);
        end
    endtask

    task automatic bus_write(input int a, input int d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = ADDR_W'(a); reg_wdata = 8'(d);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_read(input int a, output int d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = ADDR_W'(a);
        @(negedge clk);
        reg_rd = 1'b0;
        d = int'(reg_rdata);
    endtask

    task automatic pulse_ovf(input int txm, input int rxm);
        @(negedge clk);
        tx_ovf = NUM_CH'(txm); rx_ovf = NUM_CH'(rxm);
        @(negedge clk);
        tx_ovf = '0; rx_ovf = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (txm[c]) m_txfo[c] = 1;
            if (rxm[c]) m_rxfo[c] = 1;
        end
    endtask

    task automatic clear_read(input int c, input bit is_tx);
        int d;
        bus_read(adr(c, is_tx ? 2 : 3), d);
        chk("R5 clear read value", d, is_tx ? m_txfo[c] : m_rxfo[c]);
        if (is_tx) m_txfo[c] = 0; else m_rxfo[c] = 0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int d;
        void'($urandom(32'h5eed_a0d1));
        for (int c = 0; c < NUM_CH; c++) begin
            m_tx_lvl[c] = 0; m_rx_lvl[c] = 0; m_txtrig[c] = 0; m_rxtrig[c] = 0;
            m_mask[c] = 8'h33; m_txfo[c] = 0; m_rxfo[c] = 0;
        end
        tick(3);
        rst_n = 1'b1;
        tick(2);

        // R1 reset state
        chk("R1 irq after reset", int'(irq), 0);
        chk("R1 tx_flush after reset", int'(tx_flush), 0);
        chk("R1 rx_flush after reset", int'(rx_flush), 0);
        for (int c = 0; c < NUM_CH; c++) begin
            bus_read(adr(c, 1), d); chk("R1 mask reset", d, 8'h33);
            bus_read(adr(c, 4), d); chk("R1 tx trig reset", d, 0);
            bus_read(adr(c, 0), d); chk("R1 status reset", d, exp_status(c));
        end

        // R9 trigger read back; R2 boundary on ch1
        bus_write(adr(1, 4), 5); m_txtrig[1] = 5;
        bus_read(adr(1, 4), d); chk("R9 tx trig readback", d, 5);
        m_tx_lvl[1] = 5; apply_levels();
        bus_read(adr(1, 0), d); chk("R2 level equal to trig", d & 8'h10, 8'h10);
        m_tx_lvl[1] = 6; apply_levels();
        bus_read(adr(1, 0), d); chk("R2 level above trig", d & 8'h10, 0);

        // R3 boundary on ch2
        bus_write(adr(2, 5), 3); m_rxtrig[2] = 3;
        bus_read(adr(2, 5), d); chk("R9 rx trig readback", d, 3);
        m_rx_lvl[2] = 3; apply_levels();
        bus_read(adr(2, 0), d); chk("R3 level equal to trig", d & 8'h01, 0);
        m_rx_lvl[2] = 4; apply_levels();
        bus_read(adr(2, 0), d); chk("R3 level above trig", d & 8'h01, 8'h01);

        // R7 mask implemented bits
        bus_write(adr(0, 1), 8'hFF);
        bus_read(adr(0, 1), d); chk("R7 mask reserved bits", d, 8'h33);
        bus_write(adr(0, 1), 8'h00); m_mask[0] = 0;
        bus_read(adr(0, 1), d); chk("R7 mask cleared", d, 0);
        bus_write(adr(0, 1), 8'h33); m_mask[0] = 8'h33;
        tick(2);
        chk("R7 all masked no irq", int'(irq), 0);

        // R8 irq latency: unmask rx ready of ch0 only
        bus_write(adr(0, 1), 8'h32); m_mask[0] = 8'h32;
        tick(2);
        chk("R8 irq before level", int'(irq), 0);
        m_rx_lvl[0] = 2; apply_levels();
        tick(1);
        chk("R8 irq one clock after level", int'(irq), 0);
        tick(1);
        chk("R8 irq two clocks after level", int'(irq), 1);
        m_rx_lvl[0] = 0; apply_levels();
        tick(2);
        chk("R8 irq falls", int'(irq), 0);

        // R4 sticky overrun, R5 selective clear
        pulse_ovf(4'b1000, 4'b1000);
        tick(5);
        bus_read(adr(3, 0), d); chk("R4 sticky overruns", d & 8'h22, 8'h22);
        clear_read(3, 1'b1);
        bus_read(adr(3, 0), d); chk("R5 tx clear leaves rx flag", d & 8'h22, 8'h02);
        clear_read(3, 1'b1);
        clear_read(3, 1'b0);
        bus_read(adr(3, 0), d); chk("R5 both cleared", d & 8'h22, 0);

        // R6 overflow and clearing read in the same cycle
        pulse_ovf(0, 4'b0100);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = ADDR_W'(adr(2, 3)); rx_ovf = 4'b0100;
        @(negedge clk);
        reg_rd = 1'b0; rx_ovf = '0;
        chk("R6 read returns earlier value", int'(reg_rdata), 1);
        bus_read(adr(2, 0), d); chk("R6 flag survives clear", d & 8'h02, 8'h02);
        clear_read(2, 1'b0);

        // R10 flush pulses
        bus_write(adr(0, 8), 1);
        chk("R10 tx_flush pulse", int'(tx_flush), 1);
        chk("R10 rx_flush idle", int'(rx_flush), 0);
        tick(1);
        chk("R10 tx_flush one cycle", int'(tx_flush), 0);
        bus_write(adr(3, 9), 1);
        chk("R10 rx_flush pulse", int'(rx_flush), 1);
        bus_write(adr(1, 9), 0);
        chk("R10 bit0 clear no pulse", int'(rx_flush), 0);

        // R11 / R12 unmapped index and idle read data
        bus_read(adr(1, 7), d); chk("R11 unmapped read", d, 0);
        bus_read(adr(1, 4), d); chk("R12 index 4 is tx trig", d, 5);
        tick(1);
        chk("R11 idle read data", int'(reg_rdata), 0);

        // randomized rounds
        for (int it = 0; it < 300; it++) begin
            int c;
            for (int k = 0; k < NUM_CH; k++) begin
                m_tx_lvl[k] = $urandom_range(0, 16);
                m_rx_lvl[k] = $urandom_range(0, 16);
            end
            apply_levels();
            if ($urandom_range(0, 3) == 0) begin
                c = $urandom_range(0, NUM_CH - 1);
                if ($urandom_range(0, 1) == 1) begin
                    m_txtrig[c] = $urandom_range(0, 15); bus_write(adr(c, 4), m_txtrig[c]);
                end else begin
                    m_rxtrig[c] = $urandom_range(0, 15); bus_write(adr(c, 5), m_rxtrig[c]);
                end
            end
            if ($urandom_range(0, 3) == 0) begin
                c = $urandom_range(0, NUM_CH - 1);
                d = $urandom_range(0, 255);
                bus_write(adr(c, 1), d); m_mask[c] = d & 8'h33;
            end
            if ($urandom_range(0, 9) < 3)
                pulse_ovf($urandom_range(0, 15), $urandom_range(0, 15));
            c = $urandom_range(0, NUM_CH - 1);
            bus_read(adr(c, 0), d);
            chk("R2 R3 R4 random status", d, exp_status(c));
            if ($urandom_range(0, 4) == 0)
                clear_read($urandom_range(0, NUM_CH - 1), 1'($urandom_range(0, 1)));
            tick(2);
            chk("R8 random irq", int'(irq), exp_irq());
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule